// File: doc/BRIEF.md
# Bus-Master Sensor Polling Sequencer

This block measures on-chip sensors without owning an ADC. When its sweep timer expires, it becomes a bus master and issues single write and read transactions to an external shared converter and to an analogue sensor multiplexer. It steers both through addresses and values that software has programmed. For every enabled slot it selects the converter channel and the sensor, starts a conversion, and polls a programmable valid bit. It then stores the shifted data word in that slot's result register.

Software sees one small register window. A group of global registers holds the base time unit, the interval word, the poll spacing, the poll timeout and the interrupt flag. The rest of the window is banked. Each bank has its own target addresses, write values, valid-bit description, data shift, slot enable mask, four sensor codes and four results. A select register chooses which bank the banked words address. Each sweep covers every bank in ascending order, and within each bank every enabled slot in ascending order.

Top module: `sensor_poll_seq`

## Requirements
- R1: The base unit is P*256 clocks, where P is word 1 bits 9:0 and a value of 0 counts as 1. With sensor interval S (word 2 bits 9:0) nonzero, a sweep's first request rises S*P*256+1 clocks after the idle state begins (filter interval 0). S=0 starts no sweep.
- R2: A sweep visits enabled slots in ascending order, bank 0 first. Each slot runs these transactions in order: a write of word 19 to the address in word 18; a write of the slot code (words 28+slot) to the address in word 20; a write of word 22 to the address in word 21; then the valid reads.
- R3: Word 17 bit 1 enables the converter-mux write and bit 0 enables the sensor-mux write. A cleared bit skips that transaction.
- R4: Word 26 bits 4:0 give the valid bit's position in the read data. Bit 5 set means the valid bit is active high; bit 5 clear means active low. A read that is not valid is repeated after the word 3 poll spacing.
- R5: When word 25 bit 0 is 0, the read of the word 24 address serves as both valid poll and data. When it is 1, the polls read the word 23 address and one further read of the word 24 address supplies the data.
- R6: The data word is shifted right by word 27 bits 4:0 and stored in result word 32+slot of the bank being measured.
- R7: Word 16 holds the slot enable mask. Disabled slots are not visited, and their result words stay unchanged.
- R8: When a poll read is still not valid and more than word 4 clocks have passed since polling began, irq is set and the slot is abandoned with its result unchanged. irq stays high until bit 0 of word 5 is written with 1. Word 4 resets to all ones.
- R9: Word 0 bits 3:0 select the bank that words 16 to 35 address. A select beyond the last bank reads 0, and writes made under it are ignored.
- R10: m_req, together with m_addr, m_we and m_wdata, is held stable until m_ack. Only one transaction is ever outstanding.
- R11: After reset there is no request and irq is low. Configuration and result words read 0, except word 4, which reads all ones.
- R12: Before each slot the sequencer waits the filter interval, word 2 bits 25:16, in base units.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | CAW | Register word index |
| cfg_wdata | input | DW | Register write data |
| cfg_rdata | output | DW | Register read data (combinational) |
| m_req | output | 1 | Master request |
| m_we | output | 1 | Master write (1) or read (0) |
| m_addr | output | AW | Master address |
| m_wdata | output | DW | Master write data |
| m_rdata | input | DW | Master read data, valid with m_ack |
| m_ack | input | 1 | Transaction complete |
| irq | output | 1 | Poll timeout interrupt |

## Verification
The bench builds the default configuration: two banks of four slots with 32-bit addresses and data. It programs a period of 1, so one base unit is 256 clocks, and sweep and filter intervals of a few hundred clocks can be measured exactly within a short run. A bus slave model withholds validity for a fixed number of polls. This exercises both read-control modes, both valid polarities, a nonzero shift, a skipped mux write and a timeout on one sweep. Every transaction is traced and compared against a list derived from the programmed words.

// File: rtl/sensor_poll_seq.sv
module sensor_poll_seq #(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int NSLOT = 4,
  parameter int NBANK = 2,
  parameter int CAW   = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_we,
  input  logic [CAW-1:0] cfg_addr,
  input  logic [DW-1:0]  cfg_wdata,
  output logic [DW-1:0]  cfg_rdata,
  output logic           m_req,
  output logic           m_we,
  output logic [AW-1:0]  m_addr,
  output logic [DW-1:0]  m_wdata,
  input  logic [DW-1:0]  m_rdata,
  input  logic           m_ack,
  output logic           irq
);
  localparam int NPOS = NBANK * NSLOT;
  localparam int PW   = $clog2(NPOS + 1);
  localparam int BW   = (NBANK > 1) ? $clog2(NBANK) : 1;
  localparam int SW   = (NSLOT > 1) ? $clog2(NSLOT) : 1;

  localparam int A_SEL = 0, A_PER = 1, A_INT = 2, A_POLL = 3, A_TMO = 4, A_IRQ = 5;
  localparam int A_EN = 16, A_WCTL = 17, A_MUXA = 18, A_MUXV = 19, A_PNPA = 20;
  localparam int A_ENA = 21, A_ENV = 22, A_VLDA = 23, A_VOLA = 24, A_RDC = 25;
  localparam int A_VMSK = 26, A_SHF = 27, A_CODE = 28, A_RES = A_CODE + NSLOT;

  typedef enum logic [2:0] {S_IDLE, S_GAP, S_MUX, S_PNP, S_ENA, S_VRD, S_PWAIT, S_DRD} st_t;

  logic [3:0]    sel;
  logic [9:0]    per, fint, sint;
  logic [DW-1:0] poll, tmo;
  logic [NSLOT-1:0] en   [NBANK];
  logic [1:0]       wctl [NBANK];
  logic [AW-1:0]    muxa [NBANK], pnpa [NBANK], ena_a [NBANK], vlda [NBANK], vola [NBANK];
  logic [DW-1:0]    muxv [NBANK], env [NBANK];
  logic             rdc  [NBANK];
  logic [5:0]       vmsk [NBANK];
  logic [4:0]       shf  [NBANK];
  logic [DW-1:0]    code [NBANK][NSLOT];
  logic [DW-1:0]    res  [NBANK][NSLOT];

  wire           bok = int'(sel) < NBANK;
  wire [BW-1:0]  sb  = BW'(sel);
  wire           irq_clr = cfg_we && int'(cfg_addr) == A_IRQ && cfg_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel <= '0; per <= '0; fint <= '0; sint <= '0; poll <= '0; tmo <= '1;
      for (int b = 0; b < NBANK; b++) begin
        en[b] <= '0; wctl[b] <= '0; muxa[b] <= '0; muxv[b] <= '0; pnpa[b] <= '0;
        ena_a[b] <= '0; env[b] <= '0; vlda[b] <= '0; vola[b] <= '0; rdc[b] <= 1'b0;
        vmsk[b] <= '0; shf[b] <= '0;
        for (int s = 0; s < NSLOT; s++) code[b][s] <= '0;
      end
    end else if (cfg_we) begin
      case (int'(cfg_addr))
        A_SEL:  sel  <= cfg_wdata[3:0];
        A_PER:  per  <= cfg_wdata[9:0];
        A_INT:  begin fint <= cfg_wdata[25:16]; sint <= cfg_wdata[9:0]; end
        A_POLL: poll <= cfg_wdata;
        A_TMO:  tmo  <= cfg_wdata;
        default: ;
      endcase
      if (bok) begin
        case (int'(cfg_addr))
          A_EN:   en[sb]    <= cfg_wdata[NSLOT-1:0];
          A_WCTL: wctl[sb]  <= cfg_wdata[1:0];
          A_MUXA: muxa[sb]  <= AW'(cfg_wdata);
          A_MUXV: muxv[sb]  <= cfg_wdata;
          A_PNPA: pnpa[sb]  <= AW'(cfg_wdata);
          A_ENA:  ena_a[sb] <= AW'(cfg_wdata);
          A_ENV:  env[sb]   <= cfg_wdata;
          A_VLDA: vlda[sb]  <= AW'(cfg_wdata);
          A_VOLA: vola[sb]  <= AW'(cfg_wdata);
          A_RDC:  rdc[sb]   <= cfg_wdata[0];
          A_VMSK: vmsk[sb]  <= cfg_wdata[5:0];
          A_SHF:  shf[sb]   <= cfg_wdata[4:0];
          default:
            if (int'(cfg_addr) >= A_CODE && int'(cfg_addr) < A_CODE + NSLOT)
              code[sb][SW'(int'(cfg_addr) - A_CODE)] <= cfg_wdata;
        endcase
      end
    end
  end

  always_comb begin
    cfg_rdata = '0;
    case (int'(cfg_addr))
      A_SEL:  cfg_rdata = DW'(sel);
      A_PER:  cfg_rdata = DW'(per);
      A_INT:  cfg_rdata = (DW'(fint) << 16) | DW'(sint);
      A_POLL: cfg_rdata = poll;
      A_TMO:  cfg_rdata = tmo;
      A_IRQ:  cfg_rdata = DW'(irq);
      default: ;
    endcase
    if (bok) begin
      case (int'(cfg_addr))
        A_EN:   cfg_rdata = DW'(en[sb]);
        A_WCTL: cfg_rdata = DW'(wctl[sb]);
        A_MUXA: cfg_rdata = DW'(muxa[sb]);
        A_MUXV: cfg_rdata = muxv[sb];
        A_PNPA: cfg_rdata = DW'(pnpa[sb]);
        A_ENA:  cfg_rdata = DW'(ena_a[sb]);
        A_ENV:  cfg_rdata = env[sb];
        A_VLDA: cfg_rdata = DW'(vlda[sb]);
        A_VOLA: cfg_rdata = DW'(vola[sb]);
        A_RDC:  cfg_rdata = DW'(rdc[sb]);
        A_VMSK: cfg_rdata = DW'(vmsk[sb]);
        A_SHF:  cfg_rdata = DW'(shf[sb]);
        default: begin
          if (int'(cfg_addr) >= A_CODE && int'(cfg_addr) < A_CODE + NSLOT)
            cfg_rdata = code[sb][SW'(int'(cfg_addr) - A_CODE)];
          if (int'(cfg_addr) >= A_RES && int'(cfg_addr) < A_RES + NSLOT)
            cfg_rdata = res[sb][SW'(int'(cfg_addr) - A_RES)];
        end
      endcase
    end
  end

  st_t           st, st_n;
  logic [PW-1:0] p, p_n, f_pos, n_pos;
  logic          f_ok, n_ok, store, irq_set, done;
  logic [DW-1:0] wcnt, tcnt, tgt;
  logic [NPOS-1:0] enf;

  wire [BW-1:0]  cb      = BW'(p / NSLOT);
  wire [SW-1:0]  cs      = SW'(p % NSLOT);
  wire [9:0]     per_eff = (per == '0) ? 10'd1 : per;
  wire [DW-1:0]  unit    = DW'(per_eff) << 8;
  wire           expire  = (wcnt + 1'b1) >= tgt;
  wire           vld_ok  = m_rdata[vmsk[cb][4:0]] == vmsk[cb][5];
  wire [DW-1:0]  sval    = m_rdata >> shf[cb];

  always_comb begin
    f_ok = 1'b0; f_pos = '0; n_ok = 1'b0; n_pos = '0;
    for (int i = NPOS - 1; i >= 0; i--) begin
      enf[i] = en[i / NSLOT][i % NSLOT];
      if (enf[i]) begin f_ok = 1'b1; f_pos = PW'(i); end
      if (enf[i] && PW'(i) > p) begin n_ok = 1'b1; n_pos = PW'(i); end
    end
  end

  always_comb begin
    case (st)
      S_IDLE:  tgt = DW'(sint) * unit;
      S_GAP:   tgt = DW'(fint) * unit;
      default: tgt = poll;
    endcase
  end

  always_comb begin
    st_n = st; p_n = p; store = 1'b0; irq_set = 1'b0; done = 1'b0;
    case (st)
      S_IDLE:  if (sint != '0 && expire && f_ok) begin st_n = S_GAP; p_n = f_pos; end
      S_GAP:   if (expire) st_n = wctl[cb][1] ? S_MUX : (wctl[cb][0] ? S_PNP : S_ENA);
      S_MUX:   if (m_ack) st_n = wctl[cb][0] ? S_PNP : S_ENA;
      S_PNP:   if (m_ack) st_n = S_ENA;
      S_ENA:   if (m_ack) st_n = S_VRD;
      S_VRD:
        if (m_ack) begin
          if (vld_ok) begin
            if (rdc[cb]) st_n = S_DRD;
            else begin store = 1'b1; done = 1'b1; end
          end else if (tcnt > tmo) begin
            irq_set = 1'b1; done = 1'b1;
          end else st_n = S_PWAIT;
        end
      S_PWAIT: if (expire) st_n = S_VRD;
      S_DRD:   if (m_ack) begin store = 1'b1; done = 1'b1; end
      default: st_n = S_IDLE;
    endcase
    if (done) begin
      if (n_ok) begin st_n = S_GAP; p_n = n_pos; end
      else st_n = S_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; p <= '0; wcnt <= '0; tcnt <= '0; irq <= 1'b0;
      for (int b = 0; b < NBANK; b++)
        for (int s = 0; s < NSLOT; s++) res[b][s] <= '0;
    end else begin
      st <= st_n;
      p  <= p_n;
      if (st_n != st || (st == S_IDLE && (sint == '0 || expire))) wcnt <= '0;
      else wcnt <= wcnt + 1'b1;
      if (st == S_ENA) tcnt <= '0;
      else if (st == S_VRD || st == S_PWAIT) tcnt <= tcnt + 1'b1;
      if (store) res[cb][cs] <= sval;
      if (irq_set) irq <= 1'b1;
      else if (irq_clr) irq <= 1'b0;
    end
  end

  assign m_req   = st == S_MUX || st == S_PNP || st == S_ENA || st == S_VRD || st == S_DRD;
  assign m_we    = st == S_MUX || st == S_PNP || st == S_ENA;
  assign m_wdata = (st == S_MUX) ? muxv[cb] : (st == S_PNP) ? code[cb][cs] :
                   (st == S_ENA) ? env[cb] : '0;

  always_comb begin
    case (st)
      S_MUX:   m_addr = muxa[cb];
      S_PNP:   m_addr = pnpa[cb];
      S_ENA:   m_addr = ena_a[cb];
      S_VRD:   m_addr = rdc[cb] ? vlda[cb] : vola[cb];
      S_DRD:   m_addr = vola[cb];
      default: m_addr = '0;
    endcase
  end

  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_req && !m_ack |=> m_req && $stable(m_addr) && $stable(m_we) && $stable(m_wdata));

  // R8
  irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(m_req && m_ack && !m_we));

  // R8
  irq_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(cfg_we && int'(cfg_addr) == A_IRQ && cfg_wdata[0]));

  for (genvar b = 0; b < NBANK; b++) begin : g_rb
    for (genvar s = 0; s < NSLOT; s++) begin : g_rs
      // R6
      res_upd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(res[b][s]) |-> $past(m_req && m_ack && !m_we));
    end
  end
endmodule

// File: tb/sensor_poll_seq_tb.sv
module sensor_poll_seq_tb;
  localparam int A_SEL = 0, A_PER = 1, A_INT = 2, A_POLL = 3, A_TMO = 4, A_IRQ = 5;
  localparam int A_EN = 16, A_WCTL = 17, A_MUXA = 18, A_MUXV = 19, A_PNPA = 20;
  localparam int A_ENA = 21, A_ENV = 22, A_VLDA = 23, A_VOLA = 24, A_RDC = 25;
  localparam int A_VMSK = 26, A_SHF = 27, A_CODE = 28, A_RES = 32;
  localparam int BUSY = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic cfg_we = 1'b0; logic [5:0] cfg_addr = '0; logic [31:0] cfg_wdata = '0, cfg_rdata;
  logic m_req, m_we, m_ack; logic [31:0] m_addr, m_wdata, m_rdata;
  logic irq;

  sensor_poll_seq u_dut (.clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .m_req(m_req), .m_we(m_we), .m_addr(m_addr),
    .m_wdata(m_wdata), .m_rdata(m_rdata), .m_ack(m_ack), .irq(irq));

  int cyc = 0, n_chk = 0, n_bad = 0, viol = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic hang = 1'b0;
  int busy = 0, lg_n = 0;
  logic [31:0] cur_code = '0;
  logic lg_we [256]; logic [31:0] lg_a [256], lg_d [256]; int lg_t [256];
  logic p_req = 1'b0, p_ack = 1'b0;

  function automatic logic [31:0] base(logic [31:0] c);
    return (c * 32'h0101_0101) & ~32'h1000;
  endfunction

  function automatic logic [31:0] rdfn(logic [31:0] a, int bz, logic hg, logic [31:0] c);
    logic v = (bz == 0) && !hg;
    if (a == 32'h100) return base(c) | (v ? 32'h1000 : 32'h0);
    if (a == 32'h200) return v ? 32'h0 : 32'h8;
    if (a == 32'h204) return base(c);
    return 32'h0;
  endfunction

  always @(posedge clk) begin
    p_req <= m_req; p_ack <= m_ack;
    if (p_req && !p_ack && !m_req) viol <= viol + 1;
    if (!rst_n) begin
      m_ack <= 1'b0; m_rdata <= '0;
    end else begin
      m_ack <= m_req && !m_ack;
      if (m_req && !m_ack && !m_we) m_rdata <= rdfn(m_addr, busy, hang, cur_code);
      if (m_req && m_ack) begin
        if (lg_n < 256) begin
          lg_we[lg_n] <= m_we; lg_a[lg_n] <= m_addr; lg_d[lg_n] <= m_wdata; lg_t[lg_n] <= cyc;
          lg_n <= lg_n + 1;
        end
        if (m_we && (m_addr == 32'h20 || m_addr == 32'h50)) cur_code <= m_wdata;
        if (m_we && (m_addr == 32'h30 || m_addr == 32'h60)) busy <= BUSY;
        if (!m_we && (m_addr == 32'h100 || m_addr == 32'h200) && busy > 0) busy <= busy - 1;
      end
    end
  end

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic chk_rng(string r, int act, int lo, int hi);
    n_chk++;
    if (act < lo || act > hi) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", r, act, lo, hi);
    end
  endtask

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_addr = 6'(a); cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic rd(int a, output logic [31:0] d);
    @(negedge clk); cfg_addr = 6'(a); #1 d = cfg_rdata;
  endtask

  logic       ex_we [64]; logic [31:0] ex_a [64], ex_d [64]; int ex_n = 0;
  task automatic push(logic w, logic [31:0] a, logic [31:0] d);
    ex_we[ex_n] = w; ex_a[ex_n] = a; ex_d[ex_n] = d; ex_n++;
  endtask

  initial begin
    #(200000 * 4);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [3:0]  ben  [2] = '{4'b0101, 4'b0010};
    logic [1:0]  bwc  [2] = '{2'b11, 2'b01};
    logic [31:0] bmx  [2] = '{32'h10, 32'h40};
    logic [31:0] bpn  [2] = '{32'h20, 32'h50};
    logic [31:0] ben_a[2] = '{32'h30, 32'h60};
    logic [31:0] benv [2] = '{32'h800, 32'h7};
    logic [31:0] bvl  [2] = '{32'h104, 32'h200};
    logic [31:0] bvo  [2] = '{32'h100, 32'h204};
    logic        brc  [2] = '{1'b0, 1'b1};
    logic [5:0]  bvm  [2] = '{6'h2C, 6'h03};
    logic [4:0]  bsh  [2] = '{5'd0, 5'd4};
    int t0, ta, tb, s0, nf;

    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 req", {31'b0, m_req}, 0);
    chk("R11 irq", {31'b0, irq}, 0);
    rd(A_EN, d);  chk("R11 en", d, 0);
    rd(A_RES, d); chk("R11 res", d, 0);
    rd(A_TMO, d); chk("R11 tmo", d, 32'hFFFF_FFFF);
    rst_n = 1'b1;

    for (int b = 0; b < 2; b++) begin
      wr(A_SEL, b);
      wr(A_EN, ben[b]); wr(A_WCTL, bwc[b]); wr(A_MUXA, bmx[b]); wr(A_MUXV, 32'h800);
      wr(A_PNPA, bpn[b]); wr(A_ENA, ben_a[b]); wr(A_ENV, benv[b]); wr(A_VLDA, bvl[b]);
      wr(A_VOLA, bvo[b]); wr(A_RDC, brc[b]); wr(A_VMSK, bvm[b]); wr(A_SHF, bsh[b]);
      for (int s = 0; s < 4; s++) wr(A_CODE + s, 5 + 4 * b + s);
    end
    // R9 bank select
    rd(A_EN, d); chk("R9 bank1", d, 2);
    wr(A_SEL, 0); rd(A_EN, d); chk("R9 bank0", d, 5);
    wr(A_SEL, 7); wr(A_EN, 15); rd(A_EN, d); chk("R9 absent bank reads 0", d, 0);
    wr(A_SEL, 0); rd(A_EN, d); chk("R9 absent bank write ignored", d, 5);

    for (int b = 0; b < 2; b++)
      for (int s = 0; s < 4; s++)
        if (ben[b][s]) begin
          if (bwc[b][1]) push(1'b1, bmx[b], 32'h800);
          if (bwc[b][0]) push(1'b1, bpn[b], 5 + 4 * b + s);
          push(1'b1, ben_a[b], benv[b]);
          for (int k = 0; k <= BUSY; k++) push(1'b0, brc[b] ? bvl[b] : bvo[b], 0);
          if (brc[b]) push(1'b0, bvo[b], 0);
        end

    wr(A_PER, 1); wr(A_POLL, 4);
    wr(A_INT, 2);
    t0 = cyc;
    while (!m_req) @(negedge clk);
    // R1 sweep start delay
    chk_rng("R1 start delay", cyc - t0, 512, 516);
    while (lg_n < ex_n) @(negedge clk);
    wr(A_INT, 0);
    repeat (10) @(negedge clk);
    for (int i = 0; i < ex_n; i++) begin
      chk("R2,R3,R4,R5 trace", {lg_we[i], lg_a[i][30:0]}, {ex_we[i], ex_a[i][30:0]});
      if (ex_we[i]) chk("R2 write data", lg_d[i], ex_d[i]);
    end
    ta = 0; tb = 0; nf = 0;
    for (int i = 0; i < ex_n; i++)
      if (lg_we[i] && lg_a[i] == 32'h30) begin
        if (nf == 0) ta = lg_t[i]; else tb = lg_t[i];
        nf++;
      end
    chk_rng("R12 no filter gap", tb - ta, 1, 60);
    rd(A_RES + 0, d); chk("R6 bank0 slot0", d, base(5) | 32'h1000);
    rd(A_RES + 2, d); chk("R6 bank0 slot2", d, base(7) | 32'h1000);
    rd(A_RES + 1, d); chk("R7 bank0 slot1 untouched", d, 0);
    rd(A_RES + 3, d); chk("R7 bank0 slot3 untouched", d, 0);
    wr(A_SEL, 1);
    rd(A_RES + 1, d); chk("R5,R6 bank1 slot1 shifted", d, base(10) >> 4);
    rd(A_RES + 0, d); chk("R7 bank1 slot0 untouched", d, 0);
    s0 = lg_n;
    repeat (600) @(negedge clk);
    chk("R1 zero interval stops sweeps", lg_n, s0);

    wr(A_EN, 0); wr(A_SEL, 0);
    wr(A_INT, (1 << 16) | 2);
    while (lg_n < s0 + 12) @(negedge clk);
    wr(A_INT, 0);
    repeat (10) @(negedge clk);
    nf = 0;
    for (int i = s0; i < s0 + 12; i++)
      if (lg_we[i] && lg_a[i] == 32'h30) begin
        if (nf == 0) ta = lg_t[i]; else tb = lg_t[i];
        nf++;
      end
    chk("R12 slot count", nf, 2);
    chk_rng("R12 filter gap", tb - ta, 262, 300);

    hang = 1'b1;
    wr(A_EN, 1); wr(A_TMO, 10); wr(A_POLL, 3);
    wr(A_INT, 2);
    while (!irq) @(negedge clk);
    wr(A_INT, 0);
    repeat (30) @(negedge clk);
    chk("R8 irq held", {31'b0, irq}, 1);
    rd(A_RES + 0, d); chk("R8 result kept on timeout", d, base(5) | 32'h1000);
    wr(A_IRQ, 1);
    chk("R8 irq cleared", {31'b0, irq}, 0);
    chk("R10 request dropped without ack", viol, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule